// File: doc/BRIEF.md
# Address Decoder with Sticky Remap and External Abort

This block sits between a 32-bit processor address bus and the memory system. For every access qualified by a valid strobe it classifies the address into one of three regions: on-chip memory in the bottom 4 MB, on-chip peripherals in the top 4 MB, and the external bus in between. For the external bus it resolves which of several programmable chip selects claims the address. An access that no chip select can claim raises an abort. Internal regions never abort.

At power-up the bottom 4 MB is served by the boot device on chip select 0, so the reset vector comes from non-volatile storage. Software then issues a one-way remap command. After that, internal SRAM appears at address zero and the higher chip selects become reachable. Only a reset undoes the remap.

All results are registered. They appear one clock after the access is presented and last for one cycle.

Top module: `addr_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, every select output, `abort_o`, `cs_idx_o` and `remapped_o` are 0.
- R2: Before remap, a valid access with `addr_i[31:22]` equal to 0 gives `sel_ext_o`=1 with `cs_idx_o`=0 and no abort, whatever the chip-select configuration.
- R3: After remap, a valid access anywhere in the bottom 4 MB gives `sel_int_o`=1 and no abort. This includes addresses above the 8 KB SRAM, which alias.
- R4: A valid access with `addr_i[31:22]` all ones gives `sel_periph_o`=1 and never aborts.
- R5: A valid access in the external region that hits an eligible chip select gives `sel_ext_o`=1 and that chip select's index on `cs_idx_o`. When several chip selects hit, the lowest index wins.
- R6: Before remap, only chip select 0 is eligible. An external access that only chip selects 1 and up would claim gives `abort_o`=1 and `sel_ext_o`=0.
- R7: An external access that matches no enabled chip select gives `abort_o`=1 with all selects 0. A disabled chip select (`cs_en_i` bit 0) never matches.
- R8: A cycle with `remap_wr_i`=1 and `remap_bit_i`=1 sets `remapped_o` from the next clock. Writes with `remap_bit_i`=0 leave it unchanged. Once set, it stays 1 until reset. An access in the same cycle as the write still decodes with the old mapping.
- R9: Results are registered and appear one cycle after the access. A cycle with `valid_i`=0 yields all selects 0, `cs_idx_o`=0 and `abort_o`=0, so an abort lasts one cycle per access.
- R10: Chip select i with base `cs_base_i[i]` (an address in 1 MB units, `addr_i[31:20]`) and size code k covers 2^k MB, aligned to that size. Codes 5 to 7 mean 16 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 32 | Access address |
| valid_i | input | 1 | Access strobe |
| remap_wr_i | input | 1 | Remap control register write |
| remap_bit_i | input | 1 | Remap bit value carried by the write |
| cs_en_i | input | NUM_CS | Per chip select enable |
| cs_base_i | input | NUM_CS x 12 | Per chip select base, in 1 MB units |
| cs_size_i | input | NUM_CS x 3 | Per chip select size code, log2 of size in MB |
| sel_int_o | output | 1 | Internal memory selected |
| sel_ext_o | output | 1 | External chip select driven |
| sel_periph_o | output | 1 | Internal peripheral selected |
| cs_idx_o | output | IDX_W | Index of the driven chip select |
| remapped_o | output | 1 | Remap has been performed |
| abort_o | output | 1 | Undefined external address, one-cycle pulse |

## Verification
Every decode result, the abort included, is due exactly one clock edge after the access is presented. `remapped_o` is due at the edge that closes the write cycle, while an access in that same cycle still decodes with the old mapping. The driver presents one stimulus per cycle on the falling edge and queues the result it expects for that cycle. The monitor pops one item shortly after each rising edge, so every comparison falls in the single cycle in which the result is valid. Reset checks run only once the queue has drained, and they sample both while reset is held and in the cycle after it.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_W    = 12;   // 1 MB pages: addr[31:20]
    localparam int REGION_W  = 10;   // 4 MB regions: addr[31:22]
    localparam int SIZE_W    = 3;
    localparam int MAX_LOG   = 4;    // 16 MB largest chip-select window

    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [1:0] {
        RG_LOW    = 2'd0,
        RG_EXT    = 2'd1,
        RG_PERIPH = 2'd2
    } region_e;

    typedef struct packed {
        logic sel_int;
        logic sel_ext;
        logic sel_periph;
        logic abort;
    } dec_flags_t;

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1 -: REGION_W] == '0)
            return RG_LOW;
        else if (a[ADDR_W-1 -: REGION_W] == '1)
            return RG_PERIPH;
        else
            return RG_EXT;
    endfunction

    // Window test: compare the page bits above the window size.
    function automatic logic window_hit(input page_t page, input page_t base,
                                        input logic [SIZE_W-1:0] code);
        int unsigned k;
        k = (code > SIZE_W'(MAX_LOG)) ? MAX_LOG : int'(code);
        return (page >> k) == (base >> k);
    endfunction

endpackage

// File: rtl/addr_remap_state.sv
module addr_remap_state (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic bit_i,
    output logic remapped_o
);
    always_ff @(posedge clk) begin
        if (rst)
            remapped_o <= 1'b0;
        else if (wr_i && bit_i)
            remapped_o <= 1'b1;
    end
endmodule

// File: rtl/addr_cs_match.sv
module addr_cs_match
    import addr_dec_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  page_t                          page_i,
    input  logic [NUM_CS-1:0]              elig_i,
    input  logic [NUM_CS-1:0][PAGE_W-1:0]  base_i,
    input  logic [NUM_CS-1:0][SIZE_W-1:0]  size_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o
);
    logic [NUM_CS-1:0] hits;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        assign hits[g] = elig_i[g] && window_hit(page_i, base_i[g], size_i[g]);
    end

    // Lowest index has priority.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          valid_i,
    input  logic                          remap_wr_i,
    input  logic                          remap_bit_i,
    input  logic [NUM_CS-1:0]             cs_en_i,
    input  logic [NUM_CS-1:0][PAGE_W-1:0] cs_base_i,
    input  logic [NUM_CS-1:0][SIZE_W-1:0] cs_size_i,
    output logic                          sel_int_o,
    output logic                          sel_ext_o,
    output logic                          sel_periph_o,
    output logic [IDX_W-1:0]              cs_idx_o,
    output logic                          remapped_o,
    output logic                          abort_o
);
    localparam logic [NUM_CS-1:0] BOOT_ONLY = NUM_CS'(1);

    logic              remap_q;
    logic [NUM_CS-1:0] elig;
    logic              cs_hit;
    logic [IDX_W-1:0]  cs_idx;
    region_e           region;
    dec_flags_t        flags_d, flags_q;
    logic [IDX_W-1:0]  idx_d, idx_q;

    addr_remap_state u_remap (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (remap_wr_i),
        .bit_i     (remap_bit_i),
        .remapped_o(remap_q)
    );

    assign elig = remap_q ? cs_en_i : (cs_en_i & BOOT_ONLY);

    addr_cs_match #(.NUM_CS(NUM_CS)) u_match (
        .page_i (addr_i[ADDR_W-1 -: PAGE_W]),
        .elig_i (elig),
        .base_i (cs_base_i),
        .size_i (cs_size_i),
        .hit_o  (cs_hit),
        .idx_o  (cs_idx)
    );

    assign region = classify(addr_i);

    always_comb begin
        flags_d = '0;
        idx_d   = '0;
        if (valid_i) begin
            unique case (region)
                RG_LOW: begin
                    if (remap_q) flags_d.sel_int = 1'b1;
                    else         flags_d.sel_ext = 1'b1;   // boot device, index 0
                end
                RG_PERIPH: flags_d.sel_periph = 1'b1;
                default: begin
                    if (cs_hit) begin
                        flags_d.sel_ext = 1'b1;
                        idx_d           = cs_idx;
                    end else begin
                        flags_d.abort = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            idx_q   <= '0;
        end else begin
            flags_q <= flags_d;
            idx_q   <= idx_d;
        end
    end

    assign sel_int_o    = flags_q.sel_int;
    assign sel_ext_o    = flags_q.sel_ext;
    assign sel_periph_o = flags_q.sel_periph;
    assign abort_o      = flags_q.abort;
    assign cs_idx_o     = idx_q;
    assign remapped_o   = remap_q;
endmodule

// File: rtl/addr_decoder_chk.sv
module addr_decoder_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      addr_i,
    input logic             valid_i,
    input logic             remap_wr_i,
    input logic             remap_bit_i,
    input logic             sel_int_o,
    input logic             sel_ext_o,
    input logic             sel_periph_o,
    input logic [IDX_W-1:0] cs_idx_o,
    input logic             remapped_o,
    input logic             abort_o
);
    // R9: idle cycle yields quiet outputs next cycle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !(sel_int_o || sel_ext_o || sel_periph_o || abort_o) && cs_idx_o == '0);

    // R9: at most one outcome per access
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_int_o, sel_ext_o, sel_periph_o, abort_o}));

    // R8: remap is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        remapped_o |=> remapped_o);

    // R8: remap write with bit set takes effect next cycle
    a_r8_set: assert property (@(posedge clk) disable iff (rst)
        remap_wr_i && remap_bit_i |=> remapped_o);

    // R8: no write means no change
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(remap_wr_i && remap_bit_i) && !remapped_o |=> !remapped_o);

    // R4: peripheral region never aborts
    a_r4_periph: assert property (@(posedge clk) disable iff (rst)
        valid_i && addr_i[31:22] == 10'h3FF |=> sel_periph_o && !abort_o);

    // R2: boot memory on chip select 0 before remap
    a_r2_boot: assert property (@(posedge clk) disable iff (rst)
        valid_i && addr_i[31:22] == 10'h0 && !remapped_o |=> sel_ext_o && cs_idx_o == '0 && !abort_o);

    // R3: internal memory at zero after remap
    a_r3_sram: assert property (@(posedge clk) disable iff (rst)
        valid_i && addr_i[31:22] == 10'h0 && remapped_o |=> sel_int_o && !abort_o);

    // R6: higher chip selects unreachable before remap
    a_r6_gate: assert property (@(posedge clk) disable iff (rst)
        valid_i && !remapped_o |=> !(sel_ext_o && cs_idx_o != '0));
endmodule

bind addr_decoder addr_decoder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .valid_i     (valid_i),
    .remap_wr_i  (remap_wr_i),
    .remap_bit_i (remap_bit_i),
    .sel_int_o   (sel_int_o),
    .sel_ext_o   (sel_ext_o),
    .sel_periph_o(sel_periph_o),
    .cs_idx_o    (cs_idx_o),
    .remapped_o  (remapped_o),
    .abort_o     (abort_o)
);

// File: tb/addr_decoder_tb.sv
module addr_decoder_tb;
    localparam int NUM_CS = 8;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] addr_i = '0;
    logic valid_i = 1'b0, remap_wr_i = 1'b0, remap_bit_i = 1'b0;
    logic [NUM_CS-1:0] cs_en_i = '0;
    logic [NUM_CS-1:0][11:0] cs_base_i = '0;
    logic [NUM_CS-1:0][2:0]  cs_size_i = '0;
    logic sel_int_o, sel_ext_o, sel_periph_o, remapped_o, abort_o;
    logic [IDX_W-1:0] cs_idx_o;

    always #5 clk = ~clk;

    addr_decoder #(.NUM_CS(NUM_CS)) u_dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .valid_i(valid_i),
        .remap_wr_i(remap_wr_i), .remap_bit_i(remap_bit_i),
        .cs_en_i(cs_en_i), .cs_base_i(cs_base_i), .cs_size_i(cs_size_i),
        .sel_int_o(sel_int_o), .sel_ext_o(sel_ext_o), .sel_periph_o(sel_periph_o),
        .cs_idx_o(cs_idx_o), .remapped_o(remapped_o), .abort_o(abort_o)
    );

    typedef struct packed {
        logic si; logic se; logic sp; logic [IDX_W-1:0] idx; logic ab; logic rm;
    } exp_t;

    exp_t q_exp[$];
    string q_tag[$];
    int checks = 0, errors = 0;
    logic m_remap = 1'b0;

    function automatic exp_t observed();
        exp_t o;
        o = '{si: sel_int_o, se: sel_ext_o, sp: sel_periph_o, idx: cs_idx_o,
              ab: abort_o, rm: remapped_o};
        return o;
    endfunction

    // Expected result, written from the requirements
    function automatic exp_t model(logic [31:0] a, logic v, logic rm_now, logic rm_next);
        exp_t e;
        logic [11:0] pg;
        int sz;
        e = '0;
        e.rm = rm_next;
        pg = a[31:20];
        if (!v) return e;
        if (a[31:22] == 10'h0) begin
            if (rm_now) e.si = 1'b1; else e.se = 1'b1;
        end else if (a[31:22] == 10'h3FF) begin
            e.sp = 1'b1;
        end else begin
            for (int i = 0; i < NUM_CS; i++) begin
                sz = (cs_size_i[i] > 3'd4) ? 16 : (1 << cs_size_i[i]);
                if (!e.se && cs_en_i[i] && (rm_now || i == 0) &&
                    (pg / 12'(sz)) == (cs_base_i[i] / 12'(sz))) begin
                    e.se = 1'b1;
                    e.idx = IDX_W'(i);
                end
            end
            if (!e.se) e.ab = 1'b1;
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic v, input logic wr,
                         input logic bt, input string tag);
        logic nxt;
        @(negedge clk);
        addr_i = a; valid_i = v; remap_wr_i = wr; remap_bit_i = bt;
        nxt = m_remap | (wr & bt);
        q_exp.push_back(model(a, v, m_remap, nxt));
        q_tag.push_back(tag);
        m_remap = nxt;
    endtask

    task automatic check_now(input string tag);
        exp_t o;
        o = observed();
        checks++;
        if (o != '0) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, o, exp_t'(0));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid_i = 1'b0; remap_wr_i = 1'b0; remap_bit_i = 1'b0;
        @(negedge clk);
        check_now("R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        m_remap = 1'b0;
        @(negedge clk);
        check_now("R1 after reset");
    endtask

    // Monitor: one result per cycle, due one edge after the stimulus
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                exp_t e, o;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                o = observed();
                checks++;
                if (o !== e) begin
                    errors++;
                    $display("FAIL %s: got {int,ext,per,idx,abt,rm}=%b expected %b", t, o, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // CS0 4 MB at 0x004, CS1 1 MB at 0x010, CS2 16 MB at 0x020,
        // CS3 1 MB at 0x021 (overlaps CS2), CS4 disabled at 0x040, CS5 code 7 at 0x100
        cs_base_i[0] = 12'h004; cs_size_i[0] = 3'd2;
        cs_base_i[1] = 12'h010; cs_size_i[1] = 3'd0;
        cs_base_i[2] = 12'h020; cs_size_i[2] = 3'd4;
        cs_base_i[3] = 12'h021; cs_size_i[3] = 3'd0;
        cs_base_i[4] = 12'h040; cs_size_i[4] = 3'd0;
        cs_base_i[5] = 12'h100; cs_size_i[5] = 3'd7;
        cs_en_i = 8'b0010_1111;

        repeat (2) @(negedge clk);
        check_now("R1 reset held");
        rst = 1'b0;

        drive(32'h0000_0000, 1, 0, 0, "R2 boot at zero");
        drive(32'h003F_FFFC, 1, 0, 0, "R2 boot top of low region");
        drive(32'h0050_0000, 1, 0, 0, "R5 cs0 window before remap");
        drive(32'h0100_0000, 1, 0, 0, "R6 cs1 gated before remap");
        drive(32'h0210_0000, 1, 0, 0, "R6 cs2 gated before remap");
        drive(32'hFFC0_0000, 1, 0, 0, "R4 periph before remap");
        drive(32'h0100_0000, 0, 0, 0, "R9 idle");
        drive(32'h0800_0000, 1, 0, 0, "R7 no match");
        drive(32'h0000_0000, 1, 1, 0, "R8 write of zero ignored");
        drive(32'h0000_0010, 1, 1, 1, "R8 access in write cycle uses old map");
        drive(32'h0000_0010, 1, 0, 0, "R3 sram at zero");
        drive(32'h0000_2000, 1, 0, 0, "R3 alias beyond 8 KB");
        drive(32'h003F_0000, 1, 0, 0, "R3 top of low region");
        drive(32'h0100_0004, 1, 0, 0, "R5 cs1 after remap");
        drive(32'h0110_0000, 1, 0, 0, "R10 just past cs1 1 MB");
        drive(32'h0210_0000, 1, 0, 0, "R5 overlap lowest index wins");
        drive(32'h02F0_0000, 1, 0, 0, "R10 cs2 16 MB upper end");
        drive(32'h0300_0000, 1, 0, 0, "R10 past cs2");
        drive(32'h0400_0000, 1, 0, 0, "R7 disabled cs4");
        drive(32'h10F0_0000, 1, 0, 0, "R10 size code 7 is 16 MB");
        drive(32'h0040_0000, 1, 0, 0, "R5 cs0 after remap");
        drive(32'h0800_0000, 1, 1, 0, "R8 zero write after remap keeps it");
        drive(32'hFFFF_FFFC, 1, 0, 0, "R4 periph top");
        drive(32'h0800_0000, 1, 0, 0, "R9 abort back to back");
        drive(32'h0800_0000, 0, 0, 0, "R9 abort ends");
        drive(32'hFFF0_0000, 0, 0, 0, "R9 idle periph address");
        @(negedge clk);

        do_reset();
        drive(32'h0000_0000, 1, 0, 0, "R1 remap cleared by reset");
        drive(32'h0100_0000, 1, 0, 0, "R6 gated again after reset");
        @(negedge clk);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule